// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Controller

This block decides when the transmitter may begin draining a frame from the transmit FIFO. The write side reports each beat with start and end markers and the number of bytes the beat carries. From these the block tracks the byte count of the frame being assembled, and it also counts the frames that have been written completely but not yet released. It then issues a one-cycle start strobe per frame. There are two release policies. In threshold mode, a frame is launched once enough of it is buffered, or once it is complete if it is short. In store-and-forward mode, a frame is launched only after its last byte has been written.

The block also runs a self-clearing flush. A flush request pulses a pointer reset toward the FIFO and discards every frame the block is tracking. It then keeps a busy flag high until every start strobe already issued has had its transmit status accepted by the host. When that happens the flag drops and a done pulse is issued. Frames launched before the flush stay with the transmitter, which is why their statuses must still drain.

Top module: `txq_launch_ctrl`

## Requirements
- R1: After a synchronous reset, tx_start, flush_busy, flush_done and fifo_ptr_rst are all low, and no frame or status is outstanding.
- R2: The threshold code thr_code selects a byte threshold: 0→64, 1→128, 2→192, 3→256, 4→40, 5→32, 6→24, 7→16.
- R3: In threshold mode (saf_mode=0), a frame still being written is launched in the cycle after the edge at which its accumulated byte count becomes strictly greater than the threshold. It is launched only once.
- R4: In threshold mode, a frame that completes without having been launched is launched in the cycle after the edge that writes its end beat. No earlier frame may be waiting when this happens.
- R5: In store-and-forward mode (saf_mode=1), no frame is launched before the edge that writes its end beat, whatever its size or the threshold.
- R6: Completed frames are launched in write order, at most one strobe per cycle and exactly one strobe per frame. A frame launched early and then ended in the same cycle or later is not launched again.
- R7: A flush request taken while not busy produces, in the next cycle, flush_busy high and a one-cycle fifo_ptr_rst pulse. All tracked frames are discarded and none of them is launched afterwards.
- R8: In the cycle of a flush request and during flush_busy, writes are ignored and tx_start stays low.
- R9: The number of outstanding statuses is the number of start strobes minus the stat_ack pulses; an acknowledge with nothing outstanding is ignored. flush_busy clears, with a one-cycle flush_done pulse, at the first edge after entry at which this number, including that cycle's strobe and acknowledge, is zero.
- R10: When a flush request meets a cycle in which a start would otherwise be produced, the flush wins and no strobe is issued. A strobe already high in the request cycle still counts as outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A beat is written to the FIFO this cycle |
| wr_sof | input | 1 | The beat is the first of a frame |
| wr_eof | input | 1 | The beat is the last of a frame |
| wr_bytes | input | BEAT_W | Bytes carried by the beat |
| saf_mode | input | 1 | 1: store-and-forward, 0: threshold mode |
| thr_code | input | 3 | Threshold selection code (R2) |
| flush_req | input | 1 | Flush request pulse |
| stat_ack | input | 1 | Host accepted one transmit status |
| tx_start | output | 1 | Start the next frame (one cycle per frame) |
| flush_busy | output | 1 | Self-clearing flush in progress |
| flush_done | output | 1 | One-cycle pulse when the flush finishes |
| fifo_ptr_rst | output | 1 | One-cycle FIFO pointer reset at flush entry |

## Verification
Two collisions matter most. The first is a flush request landing in the cycle in which a queued complete frame would be launched. The bench sets this up with a one-beat frame in store-and-forward mode followed at once by the request, and it expects no strobe, a pointer-reset pulse, and a flush that finishes one edge later. The second is a threshold launch falling in the same cycle as the frame's end beat. Here the bench expects exactly one strobe, with no second release of the same frame. A cycle-level reference model computed from the requirements judges these cases and a long seeded random run, in which strobes, acknowledges and flushes often coincide.

// File: rtl/txq_launch_pkg.sv
package txq_launch_pkg;

  // byte threshold selected by the 3-bit code (R2)
  function automatic logic [8:0] thr_bytes(input logic [2:0] code);
    logic [8:0] t;
    case (code)
      3'd0: t = 9'd64;
      3'd1: t = 9'd128;
      3'd2: t = 9'd192;
      3'd3: t = 9'd256;
      3'd4: t = 9'd40;
      3'd5: t = 9'd32;
      3'd6: t = 9'd24;
      default: t = 9'd16;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/txq_frame_track.sv
module txq_frame_track
  import txq_launch_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int BEAT_W = 4,
  parameter int FRM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [BEAT_W-1:0] wr_bytes,
  input  logic              saf_mode,
  input  logic [2:0]        thr_code,
  input  logic              flush_req,
  input  logic              flush_busy,
  output logic              tx_start
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cur_bytes;
  logic             cur_act;
  logic             cur_started;
  logic [FRM_W-1:0] done_cnt;

  logic             blk, have_done, part_go, go, via_done, started_now, count_eof;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] thr_ext;

  always_comb begin
    blk         = flush_req | flush_busy;
    have_done   = (done_cnt != '0);
    thr_ext     = CNT_W'(thr_bytes(thr_code));
    part_go     = !saf_mode && cur_act && !cur_started && (cur_bytes > thr_ext);
    go          = !blk && (have_done || part_go);
    via_done    = go && have_done;
    started_now = cur_started | (go & !have_done);
    sum         = {1'b0, cur_bytes} + (CNT_W+1)'(wr_bytes);
    count_eof   = wr_en && wr_eof && (wr_sof || (cur_act && !started_now));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start    <= 1'b0;
      cur_bytes   <= '0;
      cur_act     <= 1'b0;
      cur_started <= 1'b0;
      done_cnt    <= '0;
    end else if (blk) begin
      tx_start    <= 1'b0;
      cur_bytes   <= '0;
      cur_act     <= 1'b0;
      cur_started <= 1'b0;
      done_cnt    <= '0;
    end else begin
      tx_start    <= go;
      done_cnt    <= done_cnt - FRM_W'(via_done) + FRM_W'(count_eof);
      cur_started <= started_now;
      if (wr_en && wr_sof) begin
        cur_bytes   <= CNT_W'(wr_bytes);
        cur_act     <= !wr_eof;
        cur_started <= 1'b0;
      end else if (wr_en && cur_act) begin
        cur_bytes <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        if (wr_eof) begin
          cur_act     <= 1'b0;
          cur_started <= 1'b0;
        end
      end
    end
  end

  // R8
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flush_busy |=> !tx_start);

  // R5
  saf_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (saf_mode && done_cnt == '0) |=> !tx_start);

endmodule

// File: rtl/txq_flush_seq.sv
module txq_flush_seq #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_req,
  input  logic tx_start,
  input  logic stat_ack,
  output logic flush_busy,
  output logic flush_done,
  output logic fifo_ptr_rst
);

  logic [PEND_W-1:0] pend_cnt, pend_nxt;
  logic              dec;

  always_comb begin
    dec      = stat_ack && ((pend_cnt != '0) || tx_start);
    pend_nxt = pend_cnt + PEND_W'(tx_start) - PEND_W'(dec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cnt     <= '0;
      flush_busy   <= 1'b0;
      flush_done   <= 1'b0;
      fifo_ptr_rst <= 1'b0;
    end else begin
      pend_cnt     <= pend_nxt;
      flush_done   <= 1'b0;
      fifo_ptr_rst <= 1'b0;
      if (!flush_busy && flush_req) begin
        flush_busy   <= 1'b1;
        fifo_ptr_rst <= 1'b1;
      end else if (flush_busy && pend_nxt == '0) begin
        flush_busy <= 1'b0;
        flush_done <= 1'b1;
      end
    end
  end

  // R7
  ptr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_busy) |-> fifo_ptr_rst);

  // R7
  ptr_once_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_ptr_rst |=> !fifo_ptr_rst);

  // R9
  drain_done_chk: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> (!flush_busy && pend_cnt == '0 && $past(flush_busy)));

endmodule

// File: rtl/txq_launch_ctrl.sv
module txq_launch_ctrl #(
  parameter int CNT_W  = 14,
  parameter int BEAT_W = 4,
  parameter int FRM_W  = 4,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [BEAT_W-1:0] wr_bytes,
  input  logic              saf_mode,
  input  logic [2:0]        thr_code,
  input  logic              flush_req,
  input  logic              stat_ack,
  output logic              tx_start,
  output logic              flush_busy,
  output logic              flush_done,
  output logic              fifo_ptr_rst
);

  txq_frame_track #(.CNT_W(CNT_W), .BEAT_W(BEAT_W), .FRM_W(FRM_W)) u_track (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof),
    .wr_bytes(wr_bytes), .saf_mode(saf_mode), .thr_code(thr_code),
    .flush_req(flush_req), .flush_busy(flush_busy), .tx_start(tx_start)
  );

  txq_flush_seq #(.PEND_W(PEND_W)) u_flush (
    .clk(clk), .rst(rst), .flush_req(flush_req), .tx_start(tx_start),
    .stat_ack(stat_ack), .flush_busy(flush_busy), .flush_done(flush_done),
    .fifo_ptr_rst(fifo_ptr_rst)
  );

  // R10
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !tx_start);

endmodule

// File: tb/test_txq_launch_ctrl.sv
module test_txq_launch_ctrl;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_sof = 0, wr_eof = 0, saf_mode = 0, flush_req = 0, stat_ack = 0;
  logic [3:0] wr_bytes = 0;
  logic [2:0] thr_code = 0;
  logic tx_start, flush_busy, flush_done, fifo_ptr_rst;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txq_launch_ctrl i_txq_launch_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof),
    .wr_bytes(wr_bytes), .saf_mode(saf_mode), .thr_code(thr_code),
    .flush_req(flush_req), .stat_ack(stat_ack), .tx_start(tx_start),
    .flush_busy(flush_busy), .flush_done(flush_done), .fifo_ptr_rst(fifo_ptr_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // threshold expected from R2
  function automatic int exp_thr(input int code);
    return (code < 4) ? (code + 1) * 64 : 48 - 8 * (code - 3);
  endfunction

  // cycle reference model built from R3..R10
  int m_bytes, m_done, m_pend;
  bit m_act, m_st, m_start, m_busy, m_fdone, m_prst;

  always @(posedge clk) begin
    if (rst) begin
      m_bytes = 0; m_done = 0; m_pend = 0; m_act = 0; m_st = 0;
      m_start = 0; m_busy = 0; m_fdone = 0; m_prst = 0;
    end else begin
      bit blk, go, vdone, vpart, stn;
      int np;
      blk   = flush_req | m_busy;
      vdone = !blk && m_done > 0;
      vpart = !blk && !vdone && !saf_mode && m_act && !m_st && m_bytes > exp_thr(thr_code);
      go    = vdone | vpart;
      stn   = m_st | vpart;
      np = m_pend + m_start;
      if (stat_ack && np > 0) np--;
      m_pend = np;
      m_prst = 0; m_fdone = 0;
      if (!m_busy && flush_req) begin m_busy = 1; m_prst = 1; end
      else if (m_busy && np == 0) begin m_busy = 0; m_fdone = 1; end
      if (blk) begin
        m_start = 0; m_bytes = 0; m_act = 0; m_st = 0; m_done = 0;
      end else begin
        m_start = go;
        if (vdone) m_done--;
        m_st = stn;
        if (wr_en && wr_sof) begin
          m_bytes = wr_bytes; m_act = !wr_eof; m_st = 0;
          if (wr_eof) m_done++;
        end else if (wr_en && m_act) begin
          m_bytes += wr_bytes;
          if (wr_eof) begin
            m_act = 0; m_st = 0;
            if (!stn) m_done++;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(saf_mode ? "R5 tx_start" : "R3 tx_start", tx_start, m_start);
      chk("R9 flush_busy", flush_busy, m_busy);
      chk("R9 flush_done", flush_done, m_fdone);
      chk("R7 fifo_ptr_rst", fifo_ptr_rst, m_prst);
    end
  end

  task automatic beat(input bit s, input bit e, input int b);
    wr_en = 1; wr_sof = s; wr_eof = e; wr_bytes = 4'(b);
    @(negedge clk);
    wr_en = 0; wr_sof = 0; wr_eof = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack1();
    stat_ack = 1; @(negedge clk); stat_ack = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 tx_start", tx_start, 0);
    chk("R1 flush_busy", flush_busy, 0);
    chk("R1 flush_done", flush_done, 0);
    chk("R1 fifo_ptr_rst", fifo_ptr_rst, 0);
    @(negedge clk);

    // R2 / R3: partial-frame launch point for every code, 8-byte beats
    saf_mode = 0;
    for (int code = 0; code < 8; code++) begin
      int first_j;
      thr_code = 3'(code);
      first_j = 0;
      for (int j = 1; j < 40 && first_j == 0; j++) begin
        beat(j == 1, 0, 8);
        if (tx_start) first_j = j;
      end
      chk("R2 launch beat", first_j, exp_thr(code) / 8 + 2);
      beat(0, 1, 8);
      idle(2);
      chk("R3 single launch", tx_start, 0);
      ack1(); idle(1);
    end

    // R4: short complete frame, threshold 128
    thr_code = 3'd1;
    beat(1, 0, 8); beat(0, 0, 8); beat(0, 1, 8);
    chk("R4 not before end", tx_start, 0);
    idle(1);
    chk("R4 launch after end", tx_start, 1);
    idle(1); ack1(); idle(1);

    // R5: store-and-forward ignores a low threshold
    saf_mode = 1; thr_code = 3'd7;
    for (int j = 0; j < 4; j++) begin
      beat(j == 0, 0, 15);
      chk("R5 held", tx_start, 0);
    end
    beat(0, 1, 15);
    chk("R5 held at end", tx_start, 0);
    idle(1);
    chk("R5 launch", tx_start, 1);
    idle(1); ack1(); idle(1);

    // R6: two back-to-back complete frames
    beat(1, 1, 4); beat(1, 1, 4);
    chk("R6 first strobe", tx_start, 1);
    idle(1);
    chk("R6 second strobe", tx_start, 1);
    idle(1);
    chk("R6 no extra strobe", tx_start, 0);
    ack1(); ack1(); idle(1);

    // R6: threshold launch in the same cycle as the end beat
    saf_mode = 0; thr_code = 3'd7;
    beat(1, 0, 8); beat(0, 0, 8); beat(0, 0, 8); beat(0, 1, 8);
    chk("R6 early launch", tx_start, 1);
    idle(1);
    chk("R6 not relaunched", tx_start, 0);
    idle(1);
    chk("R6 still quiet", tx_start, 0);
    ack1(); idle(1);

    // R10: flush meets a pending launch
    saf_mode = 1;
    beat(1, 1, 4);
    flush_req = 1; @(negedge clk); flush_req = 0;
    chk("R10 no strobe", tx_start, 0);
    chk("R7 busy", flush_busy, 1);
    chk("R7 ptr reset", fifo_ptr_rst, 1);
    idle(1);
    chk("R9 done", flush_done, 1);
    chk("R9 busy clear", flush_busy, 0);
    idle(2);
    chk("R7 discarded frame", tx_start, 0);

    // R9 / R8: flush waits for the outstanding status, writes ignored
    saf_mode = 0; thr_code = 3'd7;
    beat(1, 1, 4); idle(2);
    flush_req = 1; @(negedge clk); flush_req = 0;
    for (int i = 0; i < 5; i++) begin
      beat(1, 1, 9);
      chk("R9 busy held", flush_busy, 1);
      chk("R8 no strobe", tx_start, 0);
    end
    ack1();
    chk("R9 done after ack", flush_done, 1);
    idle(2);
    chk("R8 writes ignored", tx_start, 0);

    // seeded random traffic against the model
    begin
      bit inf;
      inf = 0;
      for (int c = 0; c < 6000; c++) begin
        int r;
        wr_en = 0; wr_sof = 0; wr_eof = 0; flush_req = 0; stat_ack = 0;
        r = $urandom % 100;
        if (!inf) begin
          if (r < 25) begin
            wr_en = 1; wr_sof = 1; wr_bytes = 4'(1 + $urandom % 15);
            wr_eof = ($urandom % 4 == 0); inf = !wr_eof;
          end
        end else if (r < 75) begin
          wr_en = 1; wr_bytes = 4'(1 + $urandom % 15);
          wr_eof = ($urandom % 8 == 0);
          if (wr_eof) inf = 0;
        end
        if (m_pend >= 8 || (m_pend > 0 && ($urandom % 2) == 1)) stat_ack = 1;
        if ($urandom % 150 == 0) flush_req = 1;
        if (m_busy) begin saf_mode = 1'($urandom % 2); thr_code = 3'($urandom % 8); end
        @(negedge clk);
      end
      wr_en = 0; flush_req = 0; stat_ack = 0;
      idle(4);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule